// File: doc/BRIEF.md
# Serial Memory Link Initialization Controller

This block is the central state machine of a buffer device sitting on a daisy-chained, multi-lane serial memory channel. It takes the link from power-up through a calibration detour, bit and frame alignment training, per-lane testing, capability polling and width configuration, and finally into the active state that carries frames. From the active state it can also make two excursions and come back: a recalibration pause and a low-power idle.

The southbound receivers are modelled as two inputs. The first is a per-lane vector of "pattern seen" flags. The second is a code that says which pattern those flags refer to. A move between states is taken only when the expected pattern is reported on at least a runtime-programmable number of lanes, so a few dead lanes do not stall start-up. A periodic tick drives a timeout in every state that waits for the host. The outputs are the current state, the code of the pattern the link should transmit, an active flag, and a one-cycle error pulse raised when a timeout sends the machine back to the start.

Top module: `link_init_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the machine goes to Disable (state code 0). The outputs are then `tx_pattern` 0 (electrical idle), `link_active` 0 and `init_err` 0.
- R2: A move is qualified only when `hit_kind` equals the pattern the current state waits for and the number of set bits in `lane_hit` is at least `min_lanes`. The lanes may be any subset. With fewer lanes set, the state holds.
- R3: State codes are Disable 0, Calibrate 1, Training 2, Testing 3, Polling 4, Config 5, Active 6, Recalibrate 7 and LowPower 8. Pattern codes are idle 0, ones 1, TS0 2, TS1 3, TS2 4, TS3 5, frame 6 and NOP 7. The start-up path takes these moves:
  - Disable to Calibrate on ones.
  - Calibrate back to Disable on idle.
  - Disable to Training on TS0.
  - Training to Testing on TS1.
  - Testing to Polling on TS2.
  - Polling to Config on TS3.
  - Config to Active on frame.
  Each move takes effect one clock after the qualified input.
- R4: In Disable, a qualified TS0 is ignored until a Calibrate-to-Disable return has happened since the last reset or timeout.
- R5: `tx_pattern` follows the state:
  - Disable and LowPower: idle.
  - Calibrate: ones.
  - Training: TS0.
  - Testing: TS1.
  - Polling: TS2.
  - Config: TS3.
  - Active: frame.
  - Recalibrate: NOP.
- R6: `link_active` is high exactly when the state is Active.
- R7: A qualified NOP in Active moves the machine to Recalibrate. A qualified frame in Recalibrate moves it back to Active.
- R8: A qualified idle in Active moves the machine to LowPower. A qualified frame in LowPower moves it back to Active.
- R9: Every state except Disable and Active counts ticks. On the TMO_TICKS-th tick in one stay, the machine moves to Disable, drives `init_err` high for exactly that one cycle, and clears the calibration-done memory. Ticks have no effect in Disable or Active.
- R10: A qualified move in the same cycle as the expiring tick wins, with no error. The tick count restarts at every change of state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lane_hit | input | NUM_LANES | Per-lane pattern-seen flags |
| hit_kind | input | 3 | Code of the pattern the flags report |
| min_lanes | input | $clog2(NUM_LANES+1) | Minimum lane count that qualifies a move |
| tick | input | 1 | Timeout time base, one pulse per unit |
| link_state | output | 4 | Current state code |
| tx_pattern | output | 3 | Pattern code to transmit |
| link_active | output | 1 | High in the Active state |
| init_err | output | 1 | One-cycle pulse on timeout return to Disable |

## Verification
The bench builds the block with six lanes and a timeout of five ticks. With so few ticks, expiry in every timed state takes only a handful of cycles. It also lets the bench line up an expiring tick with a qualified move to check who wins. Six lanes let the bench try thresholds of zero and all lanes, and scattered lane subsets. A random phase then varies the threshold, the lane flags, the pattern code and the tick together.

// File: rtl/link_init_pkg.sv
package link_init_pkg;

  typedef enum logic [3:0] {
    ST_DISABLE = 4'd0,
    ST_CAL     = 4'd1,
    ST_TRAIN   = 4'd2,
    ST_TEST    = 4'd3,
    ST_POLL    = 4'd4,
    ST_CONFIG  = 4'd5,
    ST_ACTIVE  = 4'd6,
    ST_RECAL   = 4'd7,
    ST_LOWPWR  = 4'd8
  } link_state_e;

  typedef enum logic [2:0] {
    PAT_IDLE  = 3'd0,
    PAT_ONES  = 3'd1,
    PAT_TS0   = 3'd2,
    PAT_TS1   = 3'd3,
    PAT_TS2   = 3'd4,
    PAT_TS3   = 3'd5,
    PAT_FRAME = 3'd6,
    PAT_NOP   = 3'd7
  } link_pat_e;

  // Pattern driven on the links while in a given state.
  function automatic link_pat_e pattern_of(link_state_e s);
    case (s)
      ST_CAL:    return PAT_ONES;
      ST_TRAIN:  return PAT_TS0;
      ST_TEST:   return PAT_TS1;
      ST_POLL:   return PAT_TS2;
      ST_CONFIG: return PAT_TS3;
      ST_ACTIVE: return PAT_FRAME;
      ST_RECAL:  return PAT_NOP;
      default:   return PAT_IDLE;
    endcase
  endfunction

  // States guarded by the tick timeout.
  function automatic logic is_timed(link_state_e s);
    return (s != ST_DISABLE) && (s != ST_ACTIVE);
  endfunction

endpackage

// File: rtl/link_lane_qual.sv
module link_lane_qual #(
  parameter int NUM_LANES = 10,
  localparam int CW = $clog2(NUM_LANES + 1)
) (
  input  logic [NUM_LANES-1:0] lane_hit,
  input  logic [CW-1:0]        min_lanes,
  output logic [CW-1:0]        hit_count,
  output logic                 lanes_ok
);

  function automatic logic [CW-1:0] count_hits(logic [NUM_LANES-1:0] v);
    logic [CW-1:0] n;
    n = '0;
    for (int i = 0; i < NUM_LANES; i++) n = n + CW'(v[i]);
    return n;
  endfunction

  assign hit_count = count_hits(lane_hit);
  assign lanes_ok  = (hit_count >= min_lanes);

endmodule

// File: rtl/link_tick_timer.sv
module link_tick_timer #(
  parameter int TMO_TICKS = 1000,
  localparam int TW = $clog2(TMO_TICKS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic enable,
  input  logic tick,
  output logic expire
);

  logic [TW-1:0] ticks_seen;

  assign expire = enable && tick && (ticks_seen == TW'(TMO_TICKS - 1));

  always_ff @(posedge clk) begin
    if (rst || restart || !enable) ticks_seen <= '0;
    else if (tick)                 ticks_seen <= expire ? '0 : ticks_seen + 1'b1;
  end

  // R10: the count never passes the limit
  a_r10_count_bounded: assert property (@(posedge clk) disable iff (rst)
    ticks_seen < TW'(TMO_TICKS));

endmodule

// File: rtl/link_init_ctrl.sv
module link_init_ctrl
  import link_init_pkg::*;
#(
  parameter int NUM_LANES = 10,
  parameter int TMO_TICKS = 1000,
  localparam int CW = $clog2(NUM_LANES + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LANES-1:0] lane_hit,
  input  logic [2:0]           hit_kind,
  input  logic [CW-1:0]        min_lanes,
  input  logic                 tick,
  output logic [3:0]           link_state,
  output logic [2:0]           tx_pattern,
  output logic                 link_active,
  output logic                 init_err
);

  link_state_e state_q, move_to, state_d;
  logic        cal_done_q;
  logic        lanes_ok;
  logic [CW-1:0] hit_count;
  logic        tmo_expire;
  logic        moving;      // qualified pattern move this cycle
  logic        timing_out;  // timeout taken this cycle
  link_pat_e   seen;

  assign seen = link_pat_e'(hit_kind);

  link_lane_qual #(.NUM_LANES(NUM_LANES)) u_qual (
    .lane_hit  (lane_hit),
    .min_lanes (min_lanes),
    .hit_count (hit_count),
    .lanes_ok  (lanes_ok)
  );

  // Pattern-driven move target; equals state_q when nothing qualifies.
  always_comb begin
    move_to = state_q;
    if (lanes_ok) begin
      case (state_q)
        ST_DISABLE: begin
          if (seen == PAT_ONES)                 move_to = ST_CAL;
          else if (seen == PAT_TS0 && cal_done_q) move_to = ST_TRAIN;
        end
        ST_CAL:    if (seen == PAT_IDLE)  move_to = ST_DISABLE;
        ST_TRAIN:  if (seen == PAT_TS1)   move_to = ST_TEST;
        ST_TEST:   if (seen == PAT_TS2)   move_to = ST_POLL;
        ST_POLL:   if (seen == PAT_TS3)   move_to = ST_CONFIG;
        ST_CONFIG: if (seen == PAT_FRAME) move_to = ST_ACTIVE;
        ST_ACTIVE: begin
          if (seen == PAT_NOP)       move_to = ST_RECAL;
          else if (seen == PAT_IDLE) move_to = ST_LOWPWR;
        end
        ST_RECAL, ST_LOWPWR: if (seen == PAT_FRAME) move_to = ST_ACTIVE;
        default: move_to = ST_DISABLE;
      endcase
    end
  end

  assign moving     = (move_to != state_q);
  assign timing_out = !moving && tmo_expire;
  assign state_d    = timing_out ? ST_DISABLE : move_to;

  link_tick_timer #(.TMO_TICKS(TMO_TICKS)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (moving),
    .enable  (is_timed(state_q)),
    .tick    (tick),
    .expire  (tmo_expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_DISABLE;
      cal_done_q <= 1'b0;
      init_err   <= 1'b0;
    end else begin
      state_q  <= state_d;
      init_err <= timing_out;
      if (timing_out)                                   cal_done_q <= 1'b0;
      else if (state_q == ST_CAL && move_to == ST_DISABLE) cal_done_q <= 1'b1;
    end
  end

  assign link_state  = state_q;
  assign tx_pattern  = pattern_of(state_q);
  assign link_active = (state_q == ST_ACTIVE);

  // R9: the error pulse lasts one cycle
  a_r9_err_one_cycle: assert property (@(posedge clk) disable iff (rst)
    init_err |=> !init_err);

  // R9: an error pulse always coincides with Disable
  a_r9_err_in_disable: assert property (@(posedge clk) disable iff (rst)
    init_err |-> (link_state == 4'd0));

  // R2: a non-timeout change of state needs a qualified lane count
  a_r2_move_needs_lanes: assert property (@(posedge clk) disable iff (rst)
    (moving && !tmo_expire) |-> lanes_ok);

  // R4: no training before calibration has completed
  a_r4_no_train_uncal: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DISABLE && !cal_done_q) |=> (state_q != ST_TRAIN));

  // R3: Active is reached only from Config, Recalibrate or LowPower
  a_r3_active_entry: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_ACTIVE) |=> (state_q != ST_ACTIVE ||
      $past(state_q) == ST_CONFIG || $past(state_q) == ST_RECAL ||
      $past(state_q) == ST_LOWPWR));

  // R10: a qualified move beats an expiring tick
  a_r10_move_wins: assert property (@(posedge clk) disable iff (rst)
    (moving && tmo_expire) |=> !init_err);

endmodule

// File: tb/sim_link_init_ctrl.sv
`timescale 1ns/1ps
module sim_link_init_ctrl;
  localparam int N   = 6;
  localparam int TMO = 5;
  localparam int CW  = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst;
  logic [N-1:0] lane_hit;
  logic [2:0] hit_kind;
  logic [CW-1:0] min_lanes;
  logic tick;
  logic [3:0] link_state;
  logic [2:0] tx_pattern;
  logic link_active, init_err;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  link_init_ctrl #(.NUM_LANES(N), .TMO_TICKS(TMO)) u0 (
    .clk(clk), .rst(rst), .lane_hit(lane_hit), .hit_kind(hit_kind),
    .min_lanes(min_lanes), .tick(tick), .link_state(link_state),
    .tx_pattern(tx_pattern), .link_active(link_active), .init_err(init_err)
  );

  // Reference model
  int m_st = 0, m_cnt = 0;
  bit m_cal = 0, m_err = 0;
  int pat_tbl[9] = '{0, 1, 2, 3, 4, 5, 6, 7, 0};

  always @(posedge clk) begin
    int nx, ones;
    bit ok;
    if (rst) begin
      m_st = 0; m_cal = 0; m_cnt = 0; m_err = 0;
    end else begin
      ones = $countones(lane_hit);
      ok = ones >= min_lanes;
      nx = m_st;
      if (ok) begin
        if (m_st == 0 && hit_kind == 1) nx = 1;
        else if (m_st == 0 && hit_kind == 2 && m_cal) nx = 2;
        else if (m_st == 1 && hit_kind == 0) nx = 0;
        else if (m_st >= 2 && m_st <= 5 && hit_kind == m_st + 1) nx = m_st + 1;
        else if (m_st == 6 && hit_kind == 7) nx = 7;
        else if (m_st == 6 && hit_kind == 0) nx = 8;
        else if ((m_st == 7 || m_st == 8) && hit_kind == 6) nx = 6;
      end
      m_err = 0;
      if (nx != m_st) begin
        if (m_st == 1) m_cal = 1;
        m_st = nx; m_cnt = 0;
      end else if (m_st != 0 && m_st != 6 && tick) begin
        m_cnt++;
        if (m_cnt == TMO) begin
          m_st = 0; m_cnt = 0; m_cal = 0; m_err = 1;
        end
      end
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(link_state, m_st, "R3 state vs model");
      chk(tx_pattern, pat_tbl[m_st], "R5 pattern vs model");
      chk(link_active, m_st == 6, "R6 active vs model");
      chk(init_err, m_err, "R9 error pulse vs model");
    end
  end

  task automatic finish_run;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Apply one cycle of stimulus, then return to quiet inputs.
  task automatic step(input int kind, input logic [N-1:0] hits, input bit tk);
    @(posedge clk); #1;
    hit_kind = kind[2:0]; lane_hit = hits; tick = tk;
    @(posedge clk); #1;
    lane_hit = '0; tick = 0; hit_kind = 3'd0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(0, '0, 1);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    rst = 1; lane_hit = '0; hit_kind = 0; min_lanes = 3; tick = 0;
    repeat (4) @(posedge clk);
    #1;
    chk(link_state, 0, "R1 reset state");
    chk(tx_pattern, 0, "R1 reset pattern");
    chk(link_active, 0, "R1 reset active");
    chk(init_err, 0, "R1 reset err");
    rst = 0;

    step(2, 6'b111111, 0); chk(link_state, 0, "R4 TS0 before calibration");
    step(1, 6'b000011, 0); chk(link_state, 0, "R2 two lanes below threshold");
    step(1, 6'b101001, 0); chk(link_state, 1, "R2 scattered three lanes");
    chk(tx_pattern, 1, "R5 calibrate ones");
    step(0, 6'b110100, 0); chk(link_state, 0, "R3 back to disable");
    step(2, 6'b011010, 0); chk(link_state, 2, "R3 training");
    step(3, 6'b000111, 0); chk(link_state, 3, "R3 testing");
    step(4, 6'b111000, 0); chk(link_state, 4, "R3 polling");
    step(5, 6'b010101, 0); chk(link_state, 5, "R3 config");
    step(6, 6'b001110, 0); chk(link_state, 6, "R3 active");
    chk(link_active, 1, "R6 active high");
    ticks(TMO + 2); chk(link_state, 6, "R9 no timeout in active");
    step(7, 6'b111111, 0); chk(link_state, 7, "R7 to recalibrate");
    chk(tx_pattern, 7, "R5 NOP pattern");
    step(6, 6'b111111, 0); chk(link_state, 6, "R7 back to active");
    step(0, 6'b111111, 0); chk(link_state, 8, "R8 to low power");
    chk(tx_pattern, 0, "R5 low power idle");
    step(6, 6'b111111, 0); chk(link_state, 6, "R8 back to active");
    step(7, 6'b111111, 0);
    ticks(TMO - 1); chk(link_state, 7, "R9 not yet expired");
    @(posedge clk); #1; tick = 1;
    @(posedge clk); #1; tick = 0;
    chk(link_state, 0, "R9 timeout to disable");
    chk(init_err, 1, "R9 error pulse");
    @(posedge clk); #1; chk(init_err, 0, "R9 pulse ends");
    step(2, 6'b111111, 0); chk(link_state, 0, "R9 calibration cleared");

    // R10: qualified move wins over expiring tick
    step(1, 6'b111111, 0);
    ticks(TMO - 1);
    step(0, 6'b111111, 1);
    chk(link_state, 0, "R10 move wins");
    chk(init_err, 0, "R10 no error");
    step(2, 6'b111111, 0);
    ticks(TMO - 1);
    step(3, 6'b111111, 0); chk(link_state, 3, "R10 move restarts count");
    ticks(TMO - 1); chk(link_state, 3, "R10 fresh count");
    ticks(1); chk(link_state, 0, "R10 expiry after restart");

    // Threshold corners
    min_lanes = CW'(N);
    step(1, 6'b011111, 0); chk(link_state, 0, "R2 all lanes needed");
    step(1, 6'b111111, 0); chk(link_state, 1, "R2 all lanes present");
    min_lanes = 0;
    step(0, 6'b000000, 0); chk(link_state, 0, "R2 zero threshold");

    // Random phase, checked against the model every cycle
    for (int i = 0; i < 2000; i++) begin
      @(posedge clk); #1;
      lane_hit  = N'($urandom);
      hit_kind  = 3'($urandom_range(0, 7));
      min_lanes = CW'($urandom_range(0, N));
      tick      = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 199) == 0) rst = 1; else rst = 0;
    end
    @(posedge clk); #1; rst = 0;
    repeat (2) @(posedge clk);
    #1;
    finish_run();
  end
endmodule